// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from two external pins and three internal peripherals (two timers and a serial unit). It holds one pending flag per source and picks a single winner among the enabled sources. Each source can be placed at a high level, and a fixed order breaks ties within a level. The block gives the core a request strobe with a 16-bit service address that is fixed per source.

The core says when an instruction has completed, acknowledges a request when it begins service, and reports the return-from-interrupt instruction. The block clears the flag of the source that was served and keeps track of which priority levels are in service. A high-level request may interrupt a low-level service routine. Any other request waits until the return. Saving and restoring the program counter and status word remain inside the core.

Top module: `irqc_top`

## Requirements
- R1: Source indices are 0 = external pin 0, 1 = timer 0, 2 = external pin 1, 3 = timer 1, 4 = serial. The vector issued for source k is 0x0003 + 8*k, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R2: Any eligible source whose priority bit (bit k of `pri_reg`) is 1 beats every source whose bit is 0. Among sources of the same level, the lowest index wins.
- R3: A source is eligible only when `en_reg` bit 7 (global) and `en_reg` bit k are both 1. A masked source raises no request, but its flag stays set and visible on `pend_flags`.
- R4: `irq_req` and `irq_vec` are registered. A request rises on the clock edge that ends a cycle with `instr_done` = 1, and never while `instr_done` is 0.
- R5: While `irq_req` is 1 and `irq_ack` is 0, the request and its vector hold, even if a more urgent source arrives. An acknowledge drops `irq_req` at the next edge and clears the served source's edge or internal flag at that same edge.
- R6: While a low-level service is active, only a high-level source can raise a request. While a high-level service is active, no source can.
- R7: `reti` ends the highest active level only. A preempted low-level service stays active until a second `reti`.
- R8: An external source in level mode (`ext_edge_sel` bit 0) has its flag follow the inverted pin one cycle later. An acknowledge does not clear it.
- R9: An external source in edge mode (`ext_edge_sel` bit 1) sets its flag when the pin is high in one sample and low in the next. A pin held low sets the flag only once.
- R10: An internal event pulse sets its flag one cycle later. If a set and an acknowledge-clear fall in the same cycle, the set wins.
- R11: After synchronous reset, `irq_req`, `irq_vec`, `pend_flags` and the nesting state are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | 2 | Active-low external request pins (index 0 = source 0, index 1 = source 2) |
| ext_edge_sel | input | 2 | Per pin: 1 = falling-edge mode, 0 = level mode |
| int_evt | input | 3 | Single-cycle event pulses: timer 0, timer 1, serial |
| en_reg | input | 8 | Bit 7 is the global enable; bits 0..4 are the per-source enables |
| pri_reg | input | 8 | Bits 0..4 place a source at the high level |
| instr_done | input | 1 | The current instruction completes in this cycle |
| irq_ack | input | 1 | The core accepts the pending request |
| reti | input | 1 | A return-from-interrupt instruction executes |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Service address for the pending request |
| pend_flags | output | 5 | Pending flag of each source |

## Verification
The assertions check on every cycle that the block obeys the handshake:
- a request rises only after a completed instruction;
- the vector is legal and holds steady until it is acknowledged;
- an acknowledge withdraws the request;
- nothing starts while a high-level service is active;
- a low-level service ends only through a return when no high-level service sits above it.

Winner selection cannot be judged cycle by cycle, so the bench's scenarios cover it. The bench sweeps every subset of sources against every priority mask and compares the resulting service order with one it computes itself. Directed cases cover masking, preemption, the return order, and the flag behaviour in level, edge and set-versus-clear situations.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQC_VEC_W = 16;
  localparam int IRQC_REG_W = 8;
  localparam logic [IRQC_VEC_W-1:0] IRQC_VEC_BASE = 16'h0003;
  localparam logic [IRQC_VEC_W-1:0] IRQC_VEC_STRIDE = 16'h0008;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;
endpackage

// File: rtl/irqc_ext_flag.sv
module irqc_ext_flag (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_sel,
  input  logic clr,
  output logic flag
);
  logic pin_q;
  logic fall;

  assign fall = pin_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b1;
      flag  <= 1'b0;
    end else begin
      pin_q <= pin_n;
      if (edge_sel) flag <= fall | (flag & ~clr);
      else          flag <= ~pin_n;
    end
  end

  // R9: in edge mode a new flag needs a high sample followed by a low one
  a_r9_edge_needs_fall: assert property (@(posedge clk) disable iff (rst)
    (edge_sel && $past(edge_sel) && $rose(flag)) |-> ($past(pin_q) && !$past(pin_n)));
endmodule

// File: rtl/irqc_int_flag.sv
module irqc_int_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= evt | (flag & ~clr);
  end

  // R10: a pulse always leaves the flag set, whatever the clear did
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N_SRC = 5,
  localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] elig,
  input  logic [N_SRC-1:0] pri,
  output logic             any,
  output logic             win_hi,
  output logic [IDW-1:0]   win_id
);
  logic [N_SRC-1:0] hi_set;
  logic [N_SRC-1:0] cand;

  always_comb begin
    hi_set = elig & pri;
    win_hi = |hi_set;
    cand   = win_hi ? hi_set : elig;
    any    = |elig;
    win_id = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) win_id = IDW'(i);
    end
  end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic act_lo,
  output logic act_hi
);
  logic lo_n, hi_n;

  always_comb begin
    lo_n = act_lo;
    hi_n = act_hi;
    if (reti) begin
      if (act_hi) hi_n = 1'b0;
      else        lo_n = 1'b0;
    end
    if (take) begin
      if (take_hi) hi_n = 1'b1;
      else         lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_lo <= 1'b0;
      act_hi <= 1'b0;
    end else begin
      act_lo <= lo_n;
      act_hi <= hi_n;
    end
  end

  // R7: a low-level service ends only by a return with no high level above it
  a_r7_low_ends_last: assert property (@(posedge clk) disable iff (rst)
    $fell(act_lo) |-> ($past(reti) && !$past(act_hi)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N_EXT   = 2,
  parameter int N_INT   = 3,
  parameter int VEC_W   = irqc_pkg::IRQC_VEC_W,
  parameter int REG_W   = irqc_pkg::IRQC_REG_W,
  parameter int GIE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_pin_n,
  input  logic [N_EXT-1:0] ext_edge_sel,
  input  logic [N_INT-1:0] int_evt,
  input  logic [REG_W-1:0] en_reg,
  input  logic [REG_W-1:0] pri_reg,
  input  logic             instr_done,
  input  logic             irq_ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [N_EXT+N_INT-1:0] pend_flags
);
  import irqc_pkg::*;

  localparam int N_SRC = N_EXT + N_INT;
  localparam int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [VEC_W-1:0] VBASE   = VEC_W'(IRQC_VEC_BASE);
  localparam logic [VEC_W-1:0] VSTRIDE = VEC_W'(IRQC_VEC_STRIDE);
  localparam logic [VEC_W-1:0] VEND    = VEC_W'(IRQC_VEC_BASE + IRQC_VEC_STRIDE * N_SRC);

  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] elig;
  logic             any, win_hi;
  logic [IDW-1:0]   win_id;
  logic [IDW-1:0]   req_id;
  lvl_e             req_lvl;
  logic             act_lo, act_hi;
  logic             can_take;
  logic             take;
  logic             unused_bits;

  assign unused_bits = ^{en_reg[GIE_BIT-1:N_SRC], pri_reg[REG_W-1:N_SRC]};

  // External pins sit at even indices; internal sources fill the gaps in order.
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if ((i % 2 == 0) && (i / 2 < N_EXT)) begin : g_ext
      irqc_ext_flag u_flag (
        .clk(clk), .rst(rst), .pin_n(ext_pin_n[i/2]), .edge_sel(ext_edge_sel[i/2]),
        .clr(clr[i]), .flag(flags[i]));
    end else begin : g_int
      localparam int XI = i - (((i + 1) / 2 < N_EXT) ? (i + 1) / 2 : N_EXT);
      irqc_int_flag u_flag (
        .clk(clk), .rst(rst), .evt(int_evt[XI]), .clr(clr[i]), .flag(flags[i]));
    end
    assign clr[i] = take && (req_id == IDW'(i));
  end

  assign elig = flags & en_reg[N_SRC-1:0] & {N_SRC{en_reg[GIE_BIT]}};

  irqc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .elig(elig), .pri(pri_reg[N_SRC-1:0]), .any(any), .win_hi(win_hi), .win_id(win_id));

  assign take = irq_req && irq_ack;

  irqc_nest u_nest (
    .clk(clk), .rst(rst), .take(take), .take_hi(req_lvl == LVL_HIGH), .reti(reti),
    .act_lo(act_lo), .act_hi(act_hi));

  always_comb begin
    if (!any || act_hi) can_take = 1'b0;
    else if (act_lo)    can_take = win_hi;
    else                can_take = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      req_id  <= '0;
      req_lvl <= LVL_NONE;
    end else if (irq_req) begin
      if (irq_ack) begin
        irq_req <= 1'b0;
        req_lvl <= LVL_NONE;
      end
    end else if (instr_done && can_take) begin
      irq_req <= 1'b1;
      req_id  <= win_id;
      req_lvl <= win_hi ? LVL_HIGH : LVL_LOW;
      irq_vec <= VBASE + VEC_W'(win_id) * VSTRIDE;
    end
  end

  assign pend_flags = flags;

  a_r4_req_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(instr_done));

  a_r1_vec_legal: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((irq_vec[2:0] == VBASE[2:0]) && (irq_vec >= VBASE) && (irq_vec < VEND)));

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

  a_r5_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack) |=> !irq_req);

  a_r6_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> !$past(act_hi));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [1:0]  ext_edge_sel = 2'b11;
  logic [2:0]  int_evt = '0;
  logic [7:0]  en_reg = 8'h9F;
  logic [7:0]  pri_reg = 8'h00;
  logic        instr_done = 1'b1;
  logic        irq_ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [4:0]  pend_flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .ext_edge_sel(ext_edge_sel),
    .int_evt(int_evt), .en_reg(en_reg), .pri_reg(pri_reg), .instr_done(instr_done),
    .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
    .pend_flags(pend_flags));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(int k);
    return 16'h0003 + 16'(k) * 16'h0008;
  endfunction

  // raise sources in mask (edge-mode pins fall for one cycle, internals pulse)
  task automatic raise(logic [4:0] m);
    ext_pin_n = ~{m[2], m[0]};
    int_evt   = {m[4], m[3], m[1]};
    tick();
    ext_pin_n = 2'b11;
    int_evt   = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_ack = 0; reti = 0; int_evt = '0; ext_pin_n = 2'b11;
    ext_edge_sel = 2'b11; en_reg = 8'h9F; pri_reg = 8'h00; instr_done = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic ret();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  function automatic int pick(logic [4:0] rem, logic [4:0] pr);
    logic [4:0] c;
    c = ((rem & pr) != 0) ? (rem & pr) : rem;
    for (int k = 0; k < 5; k++) if (c[k]) return k;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    check("R11 req", 16'(irq_req), 16'h0);
    check("R11 vec", irq_vec, 16'h0);
    check("R11 pend", 16'(pend_flags), 16'h0);

    // R1 R2 sweep: every source subset against every priority mask
    for (int pm = 0; pm < 32; pm++) begin
      for (int sm = 1; sm < 32; sm++) begin
        logic [4:0] rem;
        int w;
        rem = 5'(sm);
        pri_reg = 8'(pm);
        raise(rem);
        check("R10 R9 pend set", 16'(pend_flags), 16'(rem));
        tick();
        while (rem != 0) begin
          w = pick(rem, 5'(pm));
          check("R2 req", 16'(irq_req), 16'h1);
          check("R1 R2 vec", irq_vec, vec_of(w));
          ack();
          rem[w] = 1'b0;
          check("R5 flag cleared", 16'(pend_flags), 16'(rem));
          ret();
          tick();
        end
        check("R2 idle after all", 16'(irq_req), 16'h0);
      end
    end

    // R3 global enable
    do_reset();
    en_reg = 8'h1F;
    raise(5'b01000);
    tick();
    check("R3 gie off no req", 16'(irq_req), 16'h0);
    check("R3 flag kept", 16'(pend_flags), 16'h08);
    en_reg = 8'h9F;
    tick();
    check("R3 gie on vec", irq_vec, 16'h001B);
    check("R3 gie on req", 16'(irq_req), 16'h1);
    // R3 per-source enable
    do_reset();
    en_reg = 8'h80 | 8'h1D;
    raise(5'b00010);
    tick(); tick();
    check("R3 masked src no req", 16'(irq_req), 16'h0);
    check("R3 masked flag kept", 16'(pend_flags), 16'h02);

    // R4 instruction boundary
    do_reset();
    instr_done = 1'b0;
    raise(5'b10000);
    tick(); tick(); tick();
    check("R4 no req mid-instr", 16'(irq_req), 16'h0);
    instr_done = 1'b1;
    tick();
    check("R4 req at boundary", 16'(irq_req), 16'h1);
    check("R4 vec", irq_vec, 16'h0023);

    // R5 hold, R6 low blocks low
    raise(5'b00001);
    tick();
    check("R5 vec held", irq_vec, 16'h0023);
    check("R5 req held", 16'(irq_req), 16'h1);
    ack();
    check("R5 drop", 16'(irq_req), 16'h0);
    check("R5 pend", 16'(pend_flags), 16'h01);
    tick(); tick();
    check("R6 low waits", 16'(irq_req), 16'h0);
    ret();
    tick();
    check("R7 after return", irq_vec, 16'h0003);
    check("R7 req after return", 16'(irq_req), 16'h1);

    // R6 preemption and R7 return order
    do_reset();
    pri_reg = 8'h01;
    raise(5'b10000);
    tick();
    check("R6 low start", irq_vec, 16'h0023);
    ack();
    raise(5'b00010);
    tick(); tick();
    check("R6 low blocked", 16'(irq_req), 16'h0);
    raise(5'b00001);
    tick();
    check("R6 preempt req", 16'(irq_req), 16'h1);
    check("R6 preempt vec", irq_vec, 16'h0003);
    ack();
    pri_reg = 8'h09;
    raise(5'b01000);
    tick(); tick();
    check("R6 high blocks high", 16'(irq_req), 16'h0);
    ret();
    tick();
    check("R7 high again after return", irq_vec, 16'h001B);
    ack();
    ret();
    tick(); tick();
    check("R7 low still active", 16'(irq_req), 16'h0);
    ret();
    tick();
    check("R7 low served after 2nd return", irq_vec, 16'h000B);

    // R8 level mode
    do_reset();
    ext_edge_sel = 2'b10;
    ext_pin_n = 2'b10;
    tick();
    check("R8 level flag", 16'(pend_flags), 16'h01);
    tick();
    check("R8 level vec", irq_vec, 16'h0003);
    ack();
    check("R8 ack no clear", 16'(pend_flags), 16'h01);
    ret();
    tick();
    check("R8 re-request", 16'(irq_req), 16'h1);
    ack();
    ext_pin_n = 2'b11;
    tick();
    check("R8 flag follows pin", 16'(pend_flags), 16'h00);
    ret();
    tick();
    check("R8 idle", 16'(irq_req), 16'h0);

    // R9 edge held low
    do_reset();
    ext_pin_n = 2'b01;
    tick();
    check("R9 edge flag", 16'(pend_flags), 16'h04);
    tick();
    check("R9 vec", irq_vec, 16'h0013);
    ack();
    tick(); tick(); tick();
    check("R9 held low once", 16'(pend_flags), 16'h00);
    ret();
    tick();
    check("R9 no re-request", 16'(irq_req), 16'h0);
    ext_pin_n = 2'b11;

    // R10 set beats clear
    do_reset();
    raise(5'b00010);
    tick();
    check("R10 vec", irq_vec, 16'h000B);
    irq_ack = 1'b1; int_evt = 3'b001;
    tick();
    irq_ack = 1'b0; int_evt = '0;
    check("R10 set wins", 16'(pend_flags), 16'h02);
    ret();
    tick();
    check("R10 served again", 16'(irq_req), 16'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule